// File: doc/BRIEF.md
# SONET Frame and Byte Aligner

This block takes a recovered serial bit stream, one bit per clock qualified by a valid strobe, and cuts it into bytes for a downstream framer. A 48-bit sliding window holds the most recent bits. While the framer signals out-of-frame, the block compares that window with the framing word in every clock where a bit arrives. The framing word is three 0xF6 bytes followed by three 0x28 bytes. Because the window slides one bit at a time, a match can land at any bit alignment. Each match pins the byte boundary to the bit that completed the word and raises a frame pulse alongside the final 0x28 byte.

Once the framer confirms alignment, it drops out-of-frame. The block then stops searching and keeps the last boundary it found until out-of-frame is raised again. A loss-of-signal input blanks the parallel data so that line noise never reaches the framer as valid bytes.

A two-state mode machine follows the out-of-frame input. In `ST_HOLD` the boundary is frozen. In `ST_HUNT` matches realign it. The transition `HOLD->HUNT` fires on the clock edge where out-of-frame is seen high, and `HUNT->HOLD` fires on the edge where it is seen low. Reset enters `ST_HOLD`. For each clock, the byte assembler picks one of four actions:
- `ACT_IDLE`: no bit arrives.
- `ACT_SHIFT`: a bit arrives in the middle of a byte.
- `ACT_EMIT`: the eighth bit on the current boundary arrives.
- `ACT_REALIGN`: a match arrives while hunting.

Top module: `sonet_frame_aligner`

## Requirements
- R1: After reset the parallel data is 0x00, the byte strobe and frame pulse are low, and the bit offset is 0, so the first eight valid bits form the first byte.
- R2: Bits arrive most significant first: the earliest of the eight bits of a byte appears on `par_data[7]` and the latest on `par_data[0]`.
- R3: `par_stb` pulses for one clock, one clock after the valid bit that completes a byte. Without a match, this happens once every eight valid bits. Clocks with `ser_vld` low add no bit and produce no strobe.
- R4: The framing word is F6 F6 F6 28 28 28 in hex, 48 bits sent in that order. It is detected at any bit offset, but only in the `ST_HUNT` mode.
- R5: A match in `ST_HUNT` emits at once a byte, which is 0x28, with `par_stb` and `frame_pulse` both high for that one clock. `frame_pulse` is never high without `par_stb`.
- R6: After a match, the following bytes are assembled on the new boundary, with the match bit as the last bit of a byte. Bits received before the match keep the old alignment, and any partial byte is dropped.
- R7: In `ST_HOLD` the framing word causes neither a realignment nor a frame pulse. Bytes keep the frozen boundary.
- R8: The mode register samples `oof` each clock. Bits presented one clock or more after `oof` rises are searched, and bits presented one clock or more after `oof` falls are not.
- R9: While `los` is high, `par_data` reads 0x00 in the same cycle. Strobes and alignment carry on, and the held byte shows again once `los` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Qualifies `ser_bit` in this clock |
| oof | input | 1 | Out-of-frame from framer; high enables search |
| los | input | 1 | Loss of signal; mutes parallel data |
| par_data | output | 8 | Assembled byte, MSB first received |
| par_stb | output | 1 | One-clock byte strobe |
| frame_pulse | output | 1 | One-clock pulse with the final 0x28 byte of a match |

## Verification
The bench places the framing word at several bit offsets, both mid-byte and on the existing boundary:
- A design that fails to reset the phase counter on a match would keep emitting bytes on the stale offset.
- A design that searches while holding would jump alignment or pulse with `oof` low. The bench presents the word in hold mode to catch this.

Gaps in `ser_vld` are mixed into random traffic. A design that counts clocks instead of valid bits, or that strobes on idle clocks, would then misalign. `los` toggles at random, and a design that muted late or also cleared the held byte would show wrong data when `los` drops.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_HUNT = 1'b1
    } mode_t;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_SHIFT   = 2'd1,
        ACT_EMIT    = 2'd2,
        ACT_REALIGN = 2'd3
    } asm_act_t;

endpackage

// File: rtl/sfa_mode_fsm.sv
module sfa_mode_fsm
    import sfa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oof,
    output logic hunt
);

    mode_t state_q;
    mode_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (oof)  state_d = ST_HUNT;
            ST_HUNT: if (!oof) state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        hunt = (state_q == ST_HUNT);
    end

endmodule

// File: rtl/sfa_pattern_det.sv
module sfa_pattern_det #(
    parameter int          BYTE_W  = 8,
    parameter int          A1_CNT  = 3,
    parameter int          A2_CNT  = 3,
    parameter logic [7:0]  A1_BYTE = 8'hF6,
    parameter logic [7:0]  A2_BYTE = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic              hit,
    output logic [BYTE_W-1:0] last_byte
);

    localparam int N_BYTES = A1_CNT + A2_CNT;
    localparam int PAT_W   = N_BYTES * BYTE_W;

    function automatic logic [PAT_W-1:0] build_pattern();
        logic [PAT_W-1:0] p;
        p = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            p = p << BYTE_W;
            p[BYTE_W-1:0] = (i < A1_CNT) ? A1_BYTE[BYTE_W-1:0] : A2_BYTE[BYTE_W-1:0];
        end
        return p;
    endfunction

    localparam logic [PAT_W-1:0] PATTERN = build_pattern();

    logic [PAT_W-1:0] win_q;
    logic [PAT_W-1:0] win_d;

    always_comb begin
        win_d     = {win_q[PAT_W-2:0], bit_in};
        hit       = bit_vld && (win_d == PATTERN);
        last_byte = win_d[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       win_q <= '0;
        else if (bit_vld) win_q <= win_d;
    end

endmodule

// File: rtl/sfa_byte_asm.sv
module sfa_byte_asm
    import sfa_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              hit,
    input  logic              hunt,
    input  logic [BYTE_W-1:0] last_byte,
    output logic [BYTE_W-1:0] byte_q,
    output logic              stb_q,
    output logic              fp_q
);

    localparam int              PH_W    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);

    logic [PH_W-1:0] ph_q;
    asm_act_t        act;

    always_comb begin
        if (!bit_vld)             act = ACT_IDLE;
        else if (hunt && hit)     act = ACT_REALIGN;
        else if (ph_q == PH_LAST) act = ACT_EMIT;
        else                      act = ACT_SHIFT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            byte_q <= '0;
            stb_q  <= 1'b0;
            fp_q   <= 1'b0;
        end else begin
            unique case (act)
                ACT_IDLE: begin
                    stb_q <= 1'b0;
                    fp_q  <= 1'b0;
                end
                ACT_SHIFT: begin
                    ph_q  <= ph_q + 1'b1;
                    stb_q <= 1'b0;
                    fp_q  <= 1'b0;
                end
                ACT_EMIT: begin
                    ph_q   <= '0;
                    byte_q <= last_byte;
                    stb_q  <= 1'b1;
                    fp_q   <= 1'b0;
                end
                ACT_REALIGN: begin
                    ph_q   <= '0;
                    byte_q <= last_byte;
                    stb_q  <= 1'b1;
                    fp_q   <= 1'b1;
                end
                default: begin
                    stb_q <= 1'b0;
                    fp_q  <= 1'b0;
                end
            endcase
        end
    end

    // R7
    fp_only_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fp_q |-> $past(hunt));

    // R3
    stb_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> $past(bit_vld));

endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner #(
    parameter int          BYTE_W  = 8,
    parameter int          A1_CNT  = 3,
    parameter int          A2_CNT  = 3,
    parameter logic [7:0]  A1_BYTE = 8'hF6,
    parameter logic [7:0]  A2_BYTE = 8'h28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              ser_vld,
    input  logic              oof,
    input  logic              los,
    output logic [BYTE_W-1:0] par_data,
    output logic              par_stb,
    output logic              frame_pulse
);

    logic              hunt;
    logic              hit;
    logic [BYTE_W-1:0] last_byte;
    logic [BYTE_W-1:0] byte_q;

    sfa_mode_fsm u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .oof   (oof),
        .hunt  (hunt)
    );

    sfa_pattern_det #(
        .BYTE_W  (BYTE_W),
        .A1_CNT  (A1_CNT),
        .A2_CNT  (A2_CNT),
        .A1_BYTE (A1_BYTE),
        .A2_BYTE (A2_BYTE)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (ser_bit),
        .bit_vld   (ser_vld),
        .hit       (hit),
        .last_byte (last_byte)
    );

    sfa_byte_asm #(
        .BYTE_W (BYTE_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (ser_vld),
        .hit       (hit),
        .hunt      (hunt),
        .last_byte (last_byte),
        .byte_q    (byte_q),
        .stb_q     (par_stb),
        .fp_q      (frame_pulse)
    );

    always_comb begin
        par_data = los ? '0 : byte_q;
    end

    // R5
    fp_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> par_stb);

    // R5
    fp_byte_a2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !los) |-> (par_data == A2_BYTE[BYTE_W-1:0]));

endmodule

// File: tb/sonet_frame_aligner_test.sv
module sonet_frame_aligner_test;

    localparam logic [47:0] PAT = 48'hF6F6F6_282828;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_bit = 1'b0;
    logic       ser_vld = 1'b0;
    logic       oof = 1'b0;
    logic       los = 1'b0;
    logic [7:0] par_data;
    logic       par_stb;
    logic       frame_pulse;

    always #2 clk = ~clk;

    sonet_frame_aligner uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_bit     (ser_bit),
        .ser_vld     (ser_vld),
        .oof         (oof),
        .los         (los),
        .par_data    (par_data),
        .par_stb     (par_stb),
        .frame_pulse (frame_pulse)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [47:0] m_hist = '0;
    int          m_ph   = 0;
    logic        m_hunt = 0;
    logic [7:0]  m_byte = '0;
    logic        m_stb  = 0;
    logic        m_fp   = 0;
    string       cur_req = "R1";

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R3", par_stb, m_stb);
        chk((cur_req == "R7") ? "R7" : "R5", frame_pulse, m_fp);
        chk(los ? "R9" : cur_req, par_data, los ? 0 : m_byte);
    endtask

    task automatic model_step(input logic b);
        logic h;
        m_hist = {m_hist[46:0], b};
        h = m_hunt && (m_hist == PAT);
        if (h || m_ph == 7) begin
            m_byte = m_hist[7:0];
            m_stb  = 1;
            m_fp   = h;
            m_ph   = 0;
        end else begin
            m_ph++;
            m_stb = 0;
            m_fp  = 0;
        end
    endtask

    task automatic send_bit(input logic b);
        ser_bit = b;
        ser_vld = 1'b1;
        model_step(b);
        @(negedge clk);
        ser_vld = 1'b0;
        check_all();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_pattern();
        for (int i = 47; i >= 0; i--) send_bit(PAT[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            ser_vld = 1'b0;
            m_stb = 0;
            m_fp  = 0;
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic set_oof(input logic v);
        oof = v;
        m_hunt = v;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        chk("R1", par_data, 0);
        chk("R1", par_stb, 0);
        chk("R1", frame_pulse, 0);
        idle(2);

        // R1 offset 0, R2 MSB first
        cur_req = "R2";
        send_byte(8'hA5);
        send_byte(8'h3C);
        chk("R2", par_data, 8'h3C);

        // R3 gaps in valid
        cur_req = "R3";
        for (int i = 7; i >= 0; i--) begin
            send_bit(8'h96 >> i);
            idle(i % 3);
        end

        // R4 R5 R6 realign at a mid-byte offset
        cur_req = "R6";
        set_oof(1'b1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_pattern();
        chk("R4", par_data, 8'h28);
        send_byte(8'hC3);
        chk("R6", par_data, 8'hC3);
        send_byte(8'h5A);

        // R7 hold: pattern at a new offset ignored
        cur_req = "R7";
        set_oof(1'b0);
        send_bit(1'b0); send_bit(1'b1);
        send_pattern();
        send_byte(8'h81);
        for (int i = 0; i < 6; i++) send_bit(1'b1);

        // R8 search resumes
        cur_req = "R8";
        set_oof(1'b1);
        send_bit(1'b0);
        send_pattern();
        send_byte(8'hE7);
        chk("R8", par_data, 8'hE7);

        // R9 mute and restore
        cur_req = "R9";
        los = 1'b1;
        #0;
        @(negedge clk);
        chk("R9", par_data, 0);
        send_byte(8'h77);
        los = 1'b0;
        @(negedge clk);
        m_stb = 0; m_fp = 0;
        chk("R9", par_data, 8'h77);

        // random traffic
        for (int seg = 0; seg < 40; seg++) begin
            cur_req = "R6";
            set_oof(logic'($urandom_range(0, 1)));
            if (!m_hunt) cur_req = "R7";
            for (int k = 0; k < 80; k++) begin
                int r;
                r = $urandom_range(0, 99);
                if (r < 3) los = ~los;
                if (r < 10) idle($urandom_range(1, 2));
                else if (r == 50) send_pattern();
                else send_bit(logic'($urandom_range(0, 1)));
            end
        end
        los = 1'b0;
        idle(1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule